// File: doc/BRIEF.md
# Acquisition Control Register File

This block is a small byte-addressed register file that sits between a host bridge and a sample capture engine. The host reaches it through a single-cycle write strobe and a read strobe that share one address bus. One control register walks the engine through a fixed handshake of five states: idle, armed, latch-pending, configured and running. The handshake is idle, then arm, then latch, then arm again to accept, then run. Writing the stop code returns the engine to idle from any state. Each state gives a distinct status byte when the control register is read.

Next to the control register sit shadow registers for the sample clock select, the clock divisor (stored as divide ratio minus one) and a 16-bit channel enable mask split into two bytes. The host may write the shadows at any time except while the engine runs. The sampler sees only the active copies, and these are loaded from the shadows when a configuration is accepted. While the engine runs, the block counts the sampler's tick strobes. The host can read the count as two bytes after a stop.

Top module: `acq_ctrl_regs`

## Requirements
- R1: After reset, a read of address 1 returns 0x08, `run_o` is 0 and `clk_sel_o`, `div_o` and `chan_mask_o` are all zero.
- R2: Writing 0x40 to address 1 in the idle state arms the engine, and address 1 then reads 0x40 (bit 6 = armed).
- R3: When the engine is not running, writes to address 10 (clock select, full byte stored, bit 0 driven to `clk_sel_o`), address 4 (divisor minus one) and addresses 2 and 3 (mask low and high byte) are stored and read back unchanged. These writes leave the sampler outputs untouched.
- R4: From the armed state, writing 0x42 gives status 0x42. A following write of 0x40 accepts the configuration: status becomes 0x48 (bit 3 = accepted) and the sampler outputs take the shadow values on the same clock edge.
- R5: Writing 0x41 in the configured state starts capture: `run_o` rises on that edge and status reads 0x49 (bit 0 = running).
- R6: Writing 0x00 to address 1 in any state returns the engine to idle: status 0x08 and `run_o` low after the write edge.
- R7: While running, writes to addresses 2, 3, 4 and 10 are ignored. Both the readback and the sampler outputs stay unchanged.
- R8: A control write whose code is not legal in the current state leaves the state and the status byte unchanged.
- R9: While running, each cycle with `sample_tick_i` high adds one to a 16-bit count. Address 8 returns the low byte and address 9 the high byte. The count clears when capture starts, holds when not running, and is not changed by reads.
- R10: Reads of addresses 0, 5, 6, 7 and 11 to 15 return 0x00.
- R11: `rdata_o` shows the addressed value one clock after the read strobe and holds it until the next read.
- R12: The sample count saturates at 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| sample_tick_i | input | 1 | One pulse per captured sample from the sampler |
| clk_sel_o | output | 1 | Active sample clock select |
| div_o | output | 8 | Active divisor minus one |
| chan_mask_o | output | 16 | Active channel enable mask |
| run_o | output | 1 | Capture running |

## Verification
A wrong handshake state shows at the next read of address 1 as a status byte other than the one the write sequence predicts. It also shows as `run_o` moving on the wrong edge, and both are visible one cycle after the offending write. A missing or early latch of the active copies appears on the sampler outputs straight after the accepting write, or after a shadow write. A lock that fails during capture shows there too. Counter faults appear as wrong byte values at addresses 8 and 9 after a known number of ticks, including the wrap into the high byte and the saturation point.

// File: rtl/acq_ctrl_pkg.sv
package acq_ctrl_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_LATCH,
    ST_CONFIG,
    ST_RUN
  } acq_state_e;

  // address map; mask and count bytes occupy consecutive addresses
  localparam int unsigned REG_CTRL   = 1;
  localparam int unsigned REG_MASK0  = 2;
  localparam int unsigned REG_DIV    = 4;
  localparam int unsigned REG_CNT0   = 8;
  localparam int unsigned REG_CLKSEL = 10;

  localparam logic [DATA_W-1:0] CMD_STOP  = 8'h00;
  localparam logic [DATA_W-1:0] CMD_ARM   = 8'h40;
  localparam logic [DATA_W-1:0] CMD_RUN   = 8'h41;
  localparam logic [DATA_W-1:0] CMD_LATCH = 8'h42;

  localparam int unsigned BIT_RUN   = 0;
  localparam int unsigned BIT_LATCH = 1;
  localparam int unsigned BIT_OK    = 3;
  localparam int unsigned BIT_ARM   = 6;

  localparam logic [DATA_W-1:0] STS_IDLE = 8'h08;
endpackage

// File: rtl/acq_ctrl_fsm.sv
module acq_ctrl_fsm
  import acq_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [DATA_W-1:0] ctrl_data_i,
  output logic [DATA_W-1:0] status_o,
  output logic              latch_o,
  output logic              start_o,
  output logic              running_o
);
  acq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (ctrl_wr_i) begin
      if (ctrl_data_i == CMD_STOP) begin
        state_d = ST_IDLE;
      end else begin
        case (state_q)
          ST_IDLE:   if (ctrl_data_i == CMD_ARM)   state_d = ST_ARMED;
          ST_ARMED:  if (ctrl_data_i == CMD_LATCH) state_d = ST_LATCH;
          ST_LATCH:  if (ctrl_data_i == CMD_ARM)   state_d = ST_CONFIG;
          ST_CONFIG: begin
            if (ctrl_data_i == CMD_LATCH)    state_d = ST_LATCH;
            else if (ctrl_data_i == CMD_RUN) state_d = ST_RUN;
          end
          ST_RUN:    state_d = ST_RUN;
          default:   state_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign latch_o   = ctrl_wr_i && (state_q == ST_LATCH)  && (ctrl_data_i == CMD_ARM);
  assign start_o   = ctrl_wr_i && (state_q == ST_CONFIG) && (ctrl_data_i == CMD_RUN);
  assign running_o = (state_q == ST_RUN);

  always_comb begin
    status_o            = '0;
    status_o[BIT_ARM]   = (state_q != ST_IDLE);
    status_o[BIT_OK]    = (state_q == ST_IDLE) || (state_q == ST_CONFIG) || (state_q == ST_RUN);
    status_o[BIT_LATCH] = (state_q == ST_LATCH);
    status_o[BIT_RUN]   = (state_q == ST_RUN);
  end

  // R5
  run_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(running_o) |-> ($past(status_o) == 8'h48) && $past(ctrl_wr_i) && ($past(ctrl_data_i) == CMD_RUN));

  // R6
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && ctrl_data_i == CMD_STOP) |=> (status_o == STS_IDLE) && !running_o);
endmodule

// File: rtl/acq_cfg_bank.sv
module acq_cfg_bank
  import acq_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned MASK_W = 16,   // multiple of DATA_W
  parameter int unsigned DIV_W  = 8     // at most DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              lock_i,
  input  logic              latch_i,
  output logic [MASK_W-1:0] sh_mask_o,
  output logic [DIV_W-1:0]  sh_div_o,
  output logic [DATA_W-1:0] sh_clksel_o,
  output logic [MASK_W-1:0] act_mask_o,
  output logic [DIV_W-1:0]  act_div_o,
  output logic              act_clksel_o
);
  localparam int unsigned MASK_BYTES = MASK_W / DATA_W;

  logic              wr_ok;
  logic [MASK_W-1:0] sh_mask_q, act_mask_q;
  logic [DIV_W-1:0]  sh_div_q, act_div_q;
  logic [DATA_W-1:0] sh_clksel_q;
  logic              act_clksel_q;

  assign wr_ok = wr_en_i && !lock_i;

  for (genvar g = 0; g < MASK_BYTES; g++) begin : g_mask_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_mask_q[g*DATA_W +: DATA_W] <= '0;
      end else if (wr_ok && addr_i == ADDR_W'(REG_MASK0 + g)) begin
        sh_mask_q[g*DATA_W +: DATA_W] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_div_q    <= '0;
      sh_clksel_q <= '0;
    end else if (wr_ok) begin
      if (addr_i == ADDR_W'(REG_DIV))    sh_div_q    <= wdata_i[DIV_W-1:0];
      if (addr_i == ADDR_W'(REG_CLKSEL)) sh_clksel_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_mask_q   <= '0;
      act_div_q    <= '0;
      act_clksel_q <= 1'b0;
    end else if (latch_i) begin
      act_mask_q   <= sh_mask_q;
      act_div_q    <= sh_div_q;
      act_clksel_q <= sh_clksel_q[0];
    end
  end

  assign sh_mask_o    = sh_mask_q;
  assign sh_div_o     = sh_div_q;
  assign sh_clksel_o  = sh_clksel_q;
  assign act_mask_o   = act_mask_q;
  assign act_div_o    = act_div_q;
  assign act_clksel_o = act_clksel_q;

  // R7
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable({act_mask_q, act_div_q, act_clksel_q}));

  // R7
  shadow_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && lock_i) |=> $stable({sh_mask_q, sh_div_q, sh_clksel_q}));
endmodule

// File: rtl/acq_sample_cnt.sv
module acq_sample_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   cnt_q <= '0;
    else if (clear_i)                              cnt_q <= '0;
    else if (en_i && tick_i && cnt_q != CNT_MAX)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R9
  cnt_idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clear_i) |=> $stable(cnt_q));

  // R12
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clear_i) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/acq_ctrl_regs.sv
module acq_ctrl_regs
  import acq_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned MASK_W = 16,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              sample_tick_i,
  output logic              clk_sel_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [MASK_W-1:0] chan_mask_o,
  output logic              run_o
);
  localparam int unsigned MASK_BYTES = MASK_W / DATA_W;
  localparam int unsigned CNT_BYTES  = CNT_W / DATA_W;

  logic              ctrl_wr, latch, start, running;
  logic [DATA_W-1:0] status;
  logic [MASK_W-1:0] sh_mask;
  logic [DIV_W-1:0]  sh_div;
  logic [DATA_W-1:0] sh_clksel;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rd_val, rdata_q;
  logic              addr_known;

  assign ctrl_wr = wr_en_i && (addr_i == ADDR_W'(REG_CTRL));

  acq_ctrl_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_wr_i   (ctrl_wr),
    .ctrl_data_i (wdata_i),
    .status_o    (status),
    .latch_o     (latch),
    .start_o     (start),
    .running_o   (running)
  );

  acq_cfg_bank #(
    .ADDR_W (ADDR_W),
    .MASK_W (MASK_W),
    .DIV_W  (DIV_W)
  ) u_cfg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .lock_i       (running),
    .latch_i      (latch),
    .sh_mask_o    (sh_mask),
    .sh_div_o     (sh_div),
    .sh_clksel_o  (sh_clksel),
    .act_mask_o   (chan_mask_o),
    .act_div_o    (div_o),
    .act_clksel_o (clk_sel_o)
  );

  acq_sample_cnt #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start),
    .en_i    (running),
    .tick_i  (sample_tick_i),
    .cnt_o   (cnt)
  );

  always_comb begin
    rd_val     = '0;
    addr_known = 1'b0;
    if (addr_i == ADDR_W'(REG_CTRL)) begin
      rd_val = status;     addr_known = 1'b1;
    end
    if (addr_i == ADDR_W'(REG_DIV)) begin
      rd_val = DATA_W'(sh_div); addr_known = 1'b1;
    end
    if (addr_i == ADDR_W'(REG_CLKSEL)) begin
      rd_val = sh_clksel;  addr_known = 1'b1;
    end
    for (int i = 0; i < MASK_BYTES; i++) begin
      if (addr_i == ADDR_W'(REG_MASK0 + i)) begin
        rd_val = sh_mask[i*DATA_W +: DATA_W]; addr_known = 1'b1;
      end
    end
    for (int i = 0; i < CNT_BYTES; i++) begin
      if (addr_i == ADDR_W'(REG_CNT0 + i)) begin
        rd_val = cnt[i*DATA_W +: DATA_W]; addr_known = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
  assign run_o   = running;

  // R10
  undef_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !addr_known) |=> (rdata_o == '0));

  // R11
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/acq_ctrl_regs_bench.sv
module acq_ctrl_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        clk_sel, run;
  logic [7:0]  div;
  logic [15:0] mask;

  int total = 0, passed = 0;
  bit done = 0;
  logic rd_pend = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  acq_ctrl_regs u_acq_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .sample_tick_i(tick),
    .clk_sel_o(clk_sel), .div_o(div), .chan_mask_o(mask), .run_o(run)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act === exp) passed++;
    else $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_pend <= rd_en;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        total++;
        $display("FAIL R11: actual read with no expectation, expected queued item");
      end else begin
        check(tag_q.pop_front(), {24'h0, rdata}, {24'h0, exp_q.pop_front()});
      end
    end
  end

  task automatic wr(int a, logic [7:0] d);
    wr_en = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, logic [7:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_en = 1'b1; addr = 4'(a);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ticks(int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", passed, total);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 run", {31'h0, run}, 0);
    check("R1 mask", {16'h0, mask}, 0);
    check("R1 div", {24'h0, div}, 0);
    check("R1 clksel", {31'h0, clk_sel}, 0);
    rd(1, 8'h08, "R1 status");

    // R8 illegal codes in idle
    wr(1, 8'h41); rd(1, 8'h08, "R8 run in idle");
    wr(1, 8'h42); rd(1, 8'h08, "R8 latch in idle");

    // R2 arm
    wr(1, 8'h40); rd(1, 8'h40, "R2 armed");
    wr(1, 8'h41); rd(1, 8'h40, "R8 run in armed");

    // R3 shadow writes
    wr(10, 8'h01); wr(4, 8'h09); wr(2, 8'hA5); wr(3, 8'h3C);
    rd(10, 8'h01, "R3 clksel rb"); rd(4, 8'h09, "R3 div rb");
    rd(2, 8'hA5, "R3 mask lo rb"); rd(3, 8'h3C, "R3 mask hi rb");
    check("R3 mask untouched", {16'h0, mask}, 0);
    check("R3 div untouched", {24'h0, div}, 0);

    // R4 latch handshake
    wr(1, 8'h42); rd(1, 8'h42, "R4 latch pending");
    check("R4 mask before accept", {16'h0, mask}, 0);
    wr(1, 8'h40);
    check("R4 mask", {16'h0, mask}, 32'h3CA5);
    check("R4 div", {24'h0, div}, 9);
    check("R4 clksel", {31'h0, clk_sel}, 1);
    rd(1, 8'h48, "R4 accepted");

    // R5 run
    wr(1, 8'h41);
    check("R5 run_o", {31'h0, run}, 1);
    rd(1, 8'h49, "R5 running");

    // R7 locked writes, R8 illegal in run
    wr(2, 8'hFF); wr(4, 8'h00); wr(10, 8'h00);
    rd(2, 8'hA5, "R7 mask lo locked"); rd(4, 8'h09, "R7 div locked");
    rd(10, 8'h01, "R7 clksel locked");
    check("R7 mask out", {16'h0, mask}, 32'h3CA5);
    check("R7 div out", {24'h0, div}, 9);
    wr(1, 8'h40); rd(1, 8'h49, "R8 arm in run");

    // R9 count, R6 stop
    ticks(5);
    wr(1, 8'h00);
    check("R6 run_o low", {31'h0, run}, 0);
    rd(1, 8'h08, "R6 stop from run");
    rd(8, 8'h05, "R9 cnt lo"); rd(9, 8'h00, "R9 cnt hi");
    ticks(3);
    rd(8, 8'h05, "R9 hold idle"); rd(8, 8'h05, "R9 read no side effect");

    // R11 hold without read
    @(negedge clk);
    check("R11 hold", {24'h0, rdata}, 5);

    // R10 undefined
    foreach (tag_q[k]) begin end
    for (int a = 0; a < 16; a++) begin
      if (a == 0 || (a >= 5 && a <= 7) || a >= 11) rd(a, 8'h00, "R10 undefined");
    end

    // R6 stop from armed and latch
    wr(1, 8'h40); wr(1, 8'h00); rd(1, 8'h08, "R6 stop from armed");
    wr(1, 8'h40); wr(1, 8'h42); wr(1, 8'h00); rd(1, 8'h08, "R6 stop from latch");

    // second configuration, count into high byte
    wr(1, 8'h40);
    wr(2, 8'h01); wr(3, 8'h80); wr(4, 8'h03); wr(10, 8'h00);
    wr(1, 8'h42); wr(1, 8'h40);
    check("R4 mask second", {16'h0, mask}, 32'h8001);
    check("R4 div second", {24'h0, div}, 3);
    check("R4 clksel second", {31'h0, clk_sel}, 0);
    wr(1, 8'h41);
    rd(8, 8'h00, "R9 clear on start");
    ticks(300);
    wr(1, 8'h00);
    rd(8, 8'h2C, "R9 cnt lo 300"); rd(9, 8'h01, "R9 cnt hi 300");

    // R12 saturation
    wr(1, 8'h40); wr(1, 8'h42); wr(1, 8'h40); wr(1, 8'h41);
    ticks(70000);
    wr(1, 8'h00);
    rd(8, 8'hFF, "R12 sat lo"); rd(9, 8'hFF, "R12 sat hi");

    repeat (3) @(negedge clk);
    check("R11 queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule